// File: doc/BRIEF.md
# GPIO Port with Set, Clear and Toggle Aliases

This block is a 16-pin general-purpose I/O port that sits behind a 16-byte register window on a 32-bit synchronous bus. It holds three 16-bit registers: pin direction, output data and pin enable. A pin drives its output-data bit only when both its direction bit and its enable bit are 1.

The window is organised as four 32-bit words addressed by a 2-bit word index. Byte lanes are big-endian. The halfword at the lower byte offset of a word sits in bits 31:16, and byte strobe bit 3 selects bits 31:24. The write map and the read map differ. Three write-only aliases change output-data bits without a read-modify-write: one clears bits, one sets bits and one inverts bits. The read side repeats the data and direction registers in the offsets that have no register of their own.

Reads are combinational from the current register contents and have no side effects. Writes take effect at the clock edge at which the write strobe is sampled high.

Top module: `gpio_alias_port`

## Requirements
- R1: After synchronous reset, direction, data and enable are all 0x0000. Every word reads 0, and `pin_out` and `pin_oe` are 0.
- R2: A write to word 0 bits 31:16 (offset 0x00) loads direction, and a write to word 0 bits 15:0 (offset 0x02) loads data. A write to word 1 bits 31:16 (offset 0x04) loads enable.
- R3: Strobe bit k covers write-data bits 8k+7:8k. Only bytes whose strobe is 1 take part in a write, and this holds for the aliases as well.
- R4: Writing word 1 bits 15:0 (offset 0x06) clears every data bit whose written bit is 1 and leaves the other data bits unchanged.
- R5: Writing word 2 bits 15:0 (offset 0x0A) sets every data bit whose written bit is 1 and leaves the other data bits unchanged.
- R6: Writing word 3 bits 15:0 (offset 0x0E) inverts every data bit whose written bit is 1 and leaves the other data bits unchanged.
- R7: Writes to bits 31:16 of word 2 or word 3 (offsets 0x08 and 0x0C) change no register.
- R8: Word 0 reads {direction, data}, word 1 reads {enable, data}, and words 2 and 3 read {direction, data}.
- R9: `pin_out` equals the data register, and `pin_oe` bit i is 1 exactly when direction bit i and enable bit i are both 1.
- R10: A single 32-bit write to word 1 loads enable from bits 31:16 and applies the clear alias from bits 15:0 in the same cycle.
- R11: Reads never change state. With `bus_wr` low, no register changes, whatever the other bus inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_word | input | 2 | Word index in the window (byte offset bits 3:2) |
| bus_be | input | 4 | Byte strobes, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_word` |
| pin_out | output | 16 | Pin output levels |
| pin_oe | output | 16 | Pin output enables |

## Verification
The bench builds the port at its only meaningful size: 16-bit registers on a 32-bit bus, which is four byte lanes and four words. With that size, every write map entry, every read mirror and every single-byte strobe pattern can be reached directly. The directed sequences cover partial-strobe writes to plain registers and to aliases, writes to the dead halfwords, and the combined enable-plus-clear write. Each sequence is compared against a model built from the requirements.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
    localparam int HALF_W  = 16;
    localparam int BUS_W   = 32;
    localparam int LANES   = BUS_W / 8;
    localparam int HLANES  = HALF_W / 8;
    localparam int HALVES  = BUS_W / HALF_W;
    localparam int WORDS   = 4;
    localparam int WORD_W  = $clog2(WORDS);

    typedef enum logic [2:0] {
        HOP_NONE, HOP_DIR, HOP_DATA, HOP_ENB, HOP_CLR, HOP_SET, HOP_TOG
    } half_op_e;

    typedef enum logic [1:0] {
        RSEL_DIR, RSEL_DATA, RSEL_ENB
    } rd_sel_e;

    typedef struct packed {
        half_op_e              op;
        logic [HALF_W-1:0]     val;
        logic [HALF_W-1:0]     bmask;
    } half_cmd_t;

    typedef struct packed {
        logic [HALF_W-1:0] dir;
        logic [HALF_W-1:0] data;
        logic [HALF_W-1:0] enb;
    } port_regs_t;

    // Expand per-byte strobes of one halfword into a bit mask.
    function automatic logic [HALF_W-1:0] lane_mask(input logic [HLANES-1:0] stb);
        logic [HALF_W-1:0] m;
        for (int i = 0; i < HLANES; i++) begin
            m[i*8 +: 8] = {8{stb[i]}};
        end
        return m;
    endfunction

    // Write map; half 0 is the lower byte offset (upper bits).
    function automatic half_op_e wr_map(input logic [WORD_W-1:0] word, input logic half);
        half_op_e op;
        case ({word, half})
            3'b000:  op = HOP_DIR;
            3'b001:  op = HOP_DATA;
            3'b010:  op = HOP_ENB;
            3'b011:  op = HOP_CLR;
            3'b101:  op = HOP_SET;
            3'b111:  op = HOP_TOG;
            default: op = HOP_NONE;
        endcase
        return op;
    endfunction

    // Read map with mirrors.
    function automatic rd_sel_e rd_map(input logic [WORD_W-1:0] word, input logic half);
        rd_sel_e s;
        if (half)
            s = RSEL_DATA;
        else if (word == WORD_W'(1))
            s = RSEL_ENB;
        else
            s = RSEL_DIR;
        return s;
    endfunction

    function automatic logic [HALF_W-1:0] merge(
        input logic [HALF_W-1:0] old_v,
        input logic [HALF_W-1:0] new_v,
        input logic [HALF_W-1:0] m);
        return (old_v & ~m) | (new_v & m);
    endfunction

    function automatic port_regs_t apply_cmd(input port_regs_t r, input half_cmd_t c);
        port_regs_t n;
        logic [HALF_W-1:0] hit;
        n   = r;
        hit = c.val & c.bmask;
        case (c.op)
            HOP_DIR:  n.dir  = merge(r.dir,  c.val, c.bmask);
            HOP_DATA: n.data = merge(r.data, c.val, c.bmask);
            HOP_ENB:  n.enb  = merge(r.enb,  c.val, c.bmask);
            HOP_CLR:  n.data = r.data & ~hit;
            HOP_SET:  n.data = r.data | hit;
            HOP_TOG:  n.data = r.data ^ hit;
            default:  n = r;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
    import gpio_alias_pkg::*;
(
    input  logic                        wr,
    input  logic [WORD_W-1:0]           word,
    input  logic [LANES-1:0]            be,
    input  logic [BUS_W-1:0]            wdata,
    output half_cmd_t [HALVES-1:0]      cmds
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam int TOP_BIT = BUS_W - 1 - h * HALF_W;
        localparam int TOP_STB = LANES - 1 - h * HLANES;
        logic [HLANES-1:0] stb;
        assign stb = be[TOP_STB -: HLANES];
        always_comb begin
            cmds[h].val   = wdata[TOP_BIT -: HALF_W];
            cmds[h].bmask = lane_mask(stb);
            cmds[h].op    = (wr && (|stb)) ? wr_map(word, h[0]) : HOP_NONE;
        end
    end
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_alias_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  half_cmd_t [HALVES-1:0]  cmds,
    output port_regs_t              regs
);
    port_regs_t regs_q;
    port_regs_t regs_d;

    always_comb begin
        regs_d = regs_q;
        for (int h = 0; h < HALVES; h++) begin
            regs_d = apply_cmd(regs_d, cmds[h]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assign regs = regs_q;
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_alias_pkg::*;
(
    input  logic [WORD_W-1:0]   word,
    input  port_regs_t          regs,
    output logic [BUS_W-1:0]    rdata
);
    for (genvar h = 0; h < HALVES; h++) begin : g_half
        localparam int TOP_BIT = BUS_W - 1 - h * HALF_W;
        always_comb begin
            case (rd_map(word, h[0]))
                RSEL_DATA: rdata[TOP_BIT -: HALF_W] = regs.data;
                RSEL_ENB:  rdata[TOP_BIT -: HALF_W] = regs.enb;
                default:   rdata[TOP_BIT -: HALF_W] = regs.dir;
            endcase
        end
    end
endmodule

// File: rtl/gpio_pin_drive.sv
module gpio_pin_drive
    import gpio_alias_pkg::*;
(
    input  port_regs_t          regs,
    output logic [HALF_W-1:0]   pin_out,
    output logic [HALF_W-1:0]   pin_oe
);
    for (genvar i = 0; i < HALF_W; i++) begin : g_pin
        assign pin_out[i] = regs.data[i];
        assign pin_oe[i]  = regs.dir[i] & regs.enb[i];
    end
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
    import gpio_alias_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_word,
    input  logic [LANES-1:0]    bus_be,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    output logic [HALF_W-1:0]   pin_out,
    output logic [HALF_W-1:0]   pin_oe
);
    half_cmd_t [HALVES-1:0] cmds;
    port_regs_t             regs;

    gpio_wr_decode u_dec (
        .wr    (bus_wr),
        .word  (bus_word),
        .be    (bus_be),
        .wdata (bus_wdata),
        .cmds  (cmds)
    );

    gpio_regfile u_regs (
        .clk  (clk),
        .rst  (rst),
        .cmds (cmds),
        .regs (regs)
    );

    gpio_rd_mux u_rd (
        .word  (bus_word),
        .regs  (regs),
        .rdata (bus_rdata)
    );

    gpio_pin_drive u_pins (
        .regs    (regs),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );
endmodule

// File: rtl/gpio_alias_checker.sv
module gpio_alias_checker
    import gpio_alias_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wr,
    input  logic [WORD_W-1:0]   bus_word,
    input  logic [LANES-1:0]    bus_be,
    input  logic [BUS_W-1:0]    bus_wdata,
    input  logic [HALF_W-1:0]   rd_lo,
    input  logic [HALF_W-1:0]   pin_out,
    input  logic [HALF_W-1:0]   pin_oe
);
    logic rst_q;
    always_ff @(posedge clk) rst_q <= rst;

    always @(posedge clk) begin
        if (rst_q && !rst) begin
            AST_RESET_QUIET: assert (pin_out == '0 && pin_oe == '0); // R1
        end
    end

    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == 2'd1 && bus_be[1:0] == 2'b11)
        |=> ((pin_out & $past(bus_wdata[15:0])) == '0)); // R4

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == 2'd2 && bus_be[1:0] == 2'b11)
        |=> ((pin_out & $past(bus_wdata[15:0])) == $past(bus_wdata[15:0]))); // R5

    AST_TOG_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word == 2'd3 && bus_be[1:0] == 2'b11)
        |=> (pin_out == ($past(pin_out) ^ $past(bus_wdata[15:0])))); // R6

    AST_DEAD_HALF: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_word[1] && bus_be[1:0] == 2'b00)
        |=> ($stable(pin_out) && $stable(pin_oe))); // R7

    AST_RD_DATA_MIRROR: assert property (@(posedge clk) disable iff (rst)
        rd_lo == pin_out); // R8

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !bus_wr |=> ($stable(pin_out) && $stable(pin_oe))); // R11
endmodule

bind gpio_alias_port gpio_alias_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_word  (bus_word),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .rd_lo     (bus_rdata[15:0]),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/tb_gpio_alias_port.sv
module tb_gpio_alias_port;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_word = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int n_run  = 0;
    int n_fail = 0;

    logic [15:0] m_dir = '0, m_data = '0, m_enb = '0;

    always #(CLK_P/2) clk = ~clk;

    gpio_alias_port dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] bmask(input logic [1:0] s);
        return {{8{s[1]}}, {8{s[0]}}};
    endfunction

    // Model of the write map from the requirements
    task automatic model_wr(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
        logic [15:0] mh, ml, hi, lo;
        mh = bmask(be[3:2]); ml = bmask(be[1:0]);
        hi = d[31:16]; lo = d[15:0];
        case (w)
            2'd0: begin
                m_dir  = (m_dir & ~mh) | (hi & mh);
                m_data = (m_data & ~ml) | (lo & ml);
            end
            2'd1: begin
                m_enb  = (m_enb & ~mh) | (hi & mh);
                m_data = m_data & ~(lo & ml);
            end
            2'd2: m_data = m_data | (lo & ml);
            default: m_data = m_data ^ (lo & ml);
        endcase
    endtask

    function automatic logic [31:0] exp_rd(input logic [1:0] w);
        return (w == 2'd1) ? {m_enb, m_data} : {m_dir, m_data};
    endfunction

    task automatic bus_write(input logic [1:0] w, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        model_wr(w, be, d);
    endtask

    task automatic bus_read(input logic [1:0] w, output logic [31:0] d);
        @(negedge clk);
        bus_word = w;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        for (int w = 0; w < 4; w++) begin
            bus_read(w[1:0], d);
            check(req, d, exp_rd(w[1:0]));
        end
        check(req, {16'h0, pin_out}, {16'h0, m_data});
        check(req, {16'h0, pin_oe}, {16'h0, m_dir & m_enb});
    endtask

    task automatic t_reset();
        check_all("R1");
        check("R1", {pin_out, pin_oe}, 32'h0);
    endtask

    task automatic t_basic();
        bus_write(2'd0, 4'b1111, 32'hA5C3_1234);
        bus_write(2'd1, 4'b1100, 32'h0F0F_FFFF);
        check("R2", {16'h0, m_dir}, 32'h0000_A5C3);
        check_all("R2");
        check("R9", {16'h0, pin_oe}, 32'h0000_0503);
        check("R9", {16'h0, pin_out}, 32'h0000_1234);
    endtask

    task automatic t_bytes();
        logic [31:0] d;
        bus_write(2'd0, 4'b0100, 32'hFF77_FFFF);
        bus_write(2'd0, 4'b0001, 32'hFFFF_FFEE);
        bus_read(2'd0, d);
        check("R3", d, 32'hA577_12EE);
    endtask

    task automatic t_clear();
        bus_write(2'd1, 4'b0011, 32'h0000_0204);
        check("R4", {16'h0, pin_out}, 32'h0000_10EA);
        bus_write(2'd1, 4'b0001, 32'h0000_FF08);
        check("R4", {16'h0, pin_out}, 32'h0000_10E2);
        check_all("R4");
    endtask

    task automatic t_set();
        bus_write(2'd2, 4'b0011, 32'h0000_8001);
        check("R5", {16'h0, pin_out}, 32'h0000_90E3);
        bus_write(2'd2, 4'b0010, 32'h0000_06FF);
        check("R5", {16'h0, pin_out}, 32'h0000_96E3);
    endtask

    task automatic t_tog();
        bus_write(2'd3, 4'b0011, 32'h0000_FFFF);
        check("R6", {16'h0, pin_out}, 32'h0000_691C);
        bus_write(2'd3, 4'b0011, 32'h0000_00F0);
        check("R6", {16'h0, pin_out}, 32'h0000_69EC);
        check_all("R6");
    endtask

    task automatic t_dead();
        logic [31:0] d0, d1;
        bus_write(2'd2, 4'b1100, 32'hFFFF_0000);
        bus_write(2'd3, 4'b1100, 32'h1234_0000);
        bus_read(2'd0, d0);
        bus_read(2'd1, d1);
        check("R7", d0, 32'hA577_69EC);
        check("R7", d1, 32'h0F0F_69EC);
    endtask

    task automatic t_combo();
        bus_write(2'd1, 4'b1111, 32'hFFFF_000F);
        check("R10", {16'h0, pin_out}, 32'h0000_69E0);
        check("R10", {16'h0, pin_oe}, 32'h0000_A577);
        check_all("R10");
    endtask

    task automatic t_mirror();
        logic [31:0] d;
        bus_read(2'd2, d);
        check("R8", d, 32'hA577_69E0);
        bus_read(2'd3, d);
        check("R8", d, 32'hA577_69E0);
        bus_read(2'd1, d);
        check("R8", d, 32'hFFFF_69E0);
    endtask

    task automatic t_idle();
        logic [31:0] d;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            bus_wr = 1'b0; bus_word = i[1:0]; bus_be = 4'hF; bus_wdata = 32'hDEAD_BEEF;
        end
        @(negedge clk);
        bus_be = '0;
        bus_read(2'd0, d);
        check("R11", d, 32'hA577_69E0);
        check_all("R11");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_bytes();
        t_clear();
        t_set();
        t_tog();
        t_dead();
        t_combo();
        t_mirror();
        t_idle();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule